// File: doc/BRIEF.md
# PLL Lock Monitor with Charge-Pump Current Control

This block watches the up and down pulses of a three-state phase comparator. It samples them on a fast clock and works out whether the synthesizer loop has settled. The reference divider marks the start of each comparison interval with a one-cycle tick. Inside each interval the block counts the sampling cycles in which either pulse is active. That count is the phase-error width of the interval, and the block compares it against a limit chosen by a two-bit threshold code.

Lock is declared only after a programmable run of consecutive intervals whose error stayed within the limit. A single over-limit error removes lock at once, without waiting for the end of the interval. When lock control is enabled, the lock state selects the charge-pump current: high current while unlocked, low current once locked. When lock control is disabled, a software bit selects the current instead. The current choice also picks which loop-filter input is active. A shared output pin carries either the lock flag or a general-purpose software bit.

Top module: `pll_lock_monitor`

## Requirements
- R1: The error width of an interval is the number of sampling-clock cycles in which `up_i` or `dn_i` is high. An interval runs from one `ref_tick_i` cycle up to the cycle before the next tick. The sample taken in a tick cycle belongs to the interval that the tick starts.
- R2: The width limit is (code+1)·10·`UNIT_CYC` sampling cycles for `thr_code_i` = 0..3, which gives 10, 20, 30 or 40 with the default `UNIT_CYC`=1. A width equal to the limit is accepted.
- R3: The lock flag falls at the clock edge at which the running width of the current interval reaches limit+1. No tick is needed for this. The same edge clears the run of good intervals.
- R4: The lock flag rises at the tick that closes the Nth consecutive good interval. N is 4, 6 or 8 for `dly_code_i` = 01, 10 or 11. Code 00 is treated as 8. The interval between reset (or leaving standby) and the first tick counts as an interval.
- R5: An interval that went over the limit does not count toward the run. After it, N fresh good intervals are needed before the flag rises again.
- R6: While `standby_i` is 1, the lock flag and the good-interval count are forced to zero from the next edge, and ticks are ignored.
- R7: With `lock_ctl_en_i`=1, `cp_high_o` is the inverse of the lock flag. With `lock_ctl_en_i`=0, `cp_high_o` equals `cur_hi_sw_i`, whatever the lock state.
- R8: `filt_hc_o` equals `cp_high_o`. When `cp_high_o` is 0, `filt_fm_o`=`filt_sel_i` and `filt_am_o`=!`filt_sel_i`. Exactly one of the three filter outputs is high at any time.
- R9: `shared_pin_o` shows the lock flag when `pin_sel_i`=1 and shows `gpo_i` when `pin_sel_i`=0.
- R10: After reset the lock flag is 0. With lock control enabled, this puts the charge pump in high current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Phase comparator up pulse |
| dn_i | input | 1 | Phase comparator down pulse |
| ref_tick_i | input | 1 | One-cycle marker at each reference edge |
| standby_i | input | 1 | PLL standby; clears lock state |
| thr_code_i | input | 2 | Error width threshold code |
| dly_code_i | input | 2 | Required count of good intervals |
| lock_ctl_en_i | input | 1 | Lock state drives charge-pump current |
| cur_hi_sw_i | input | 1 | Software current-high select |
| pin_sel_i | input | 1 | Shared pin source: 1 lock flag, 0 gpo |
| gpo_i | input | 1 | General-purpose output bit |
| filt_sel_i | input | 1 | Low-current filter choice: 1 FM, 0 AM |
| lock_o | output | 1 | Lock flag |
| cp_high_o | output | 1 | Charge pump in high current |
| filt_hc_o | output | 1 | High-current filter input active |
| filt_fm_o | output | 1 | FM filter input active |
| filt_am_o | output | 1 | AM filter input active |
| shared_pin_o | output | 1 | Shared lock / general-purpose pin |

## Verification
One tick cycle can do two jobs at once: it closes an interval whose width sits exactly at the limit, and it begins a new interval while the error pulse is still high. The bench provokes this by holding `up_i` high for the last ten cycles before a tick, through the tick, and on after it. The check passes if lock survives the closing of the old interval. Lock must then drop only when the new interval, with the tick-cycle sample included, reaches eleven active samples. Over-limit drops are timed to the exact edge, on both pulse polarities and on more than one threshold.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    localparam int GOOD_W = 4;

    typedef struct packed {
        logic [GOOD_W-1:0] good;
        logic              lock;
    } lock_state_t;

    typedef struct packed {
        logic cp_high;
        logic f_hc;
        logic f_fm;
        logic f_am;
        logic pin;
    } drive_t;

    // Good-interval run length required for each delay code; 00 behaves as 11.
    function automatic logic [GOOD_W-1:0] run_target(input logic [1:0] code);
        logic [GOOD_W-1:0] t;
        case (code)
            2'b01:   t = GOOD_W'(4);
            2'b10:   t = GOOD_W'(6);
            default: t = GOOD_W'(8);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pll_err_width.sv
module pll_err_width #(
    parameter int W   = 6,
    parameter int SAT = 41
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         standby_i,
    input  logic         up_i,
    input  logic         dn_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         big_o,
    output logic         tick_good_o
);
    logic [W-1:0] err_d, err_q;
    logic [W:0]   sum;
    logic [W-1:0] base;

    always_comb begin
        base = tick_i ? '0 : err_q;
        sum  = {1'b0, base} + (W+1)'(up_i | dn_i);
        if (sum > (W+1)'(SAT)) sum = (W+1)'(SAT);
        err_d       = standby_i ? '0 : W'(sum);
        big_o       = !standby_i && (sum > {1'b0, limit_i});
        tick_good_o = tick_i && !standby_i && (err_q <= limit_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q <= '0;
        else         err_q <= err_d;
    end

    // R1
    width_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !standby_i) |=> (err_q >= $past(err_q)));

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
    import pll_lock_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              standby_i,
    input  logic              tick_i,
    input  logic              tick_good_i,
    input  logic              big_i,
    input  logic [GOOD_W-1:0] target_i,
    output logic              lock_o
);
    lock_state_t st_d, st_q;
    logic [GOOD_W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        nxt  = st_q.good + GOOD_W'(st_q.good < target_i);
        if (standby_i) begin
            st_d = '0;
        end else if (big_i) begin
            st_d.good = '0;
            st_d.lock = 1'b0;
        end else if (tick_i) begin
            if (tick_good_i) begin
                st_d.good = nxt;
                st_d.lock = st_q.lock | (nxt >= target_i);
            end else begin
                st_d.good = '0;
                st_d.lock = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lock_o = st_q.lock;

    // R3
    big_drops_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        big_i |=> !st_q.lock && st_q.good == '0);
    // R6
    standby_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_i |=> !st_q.lock && st_q.good == '0);
    // R4
    lock_rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.lock) |-> $past(tick_good_i));

endmodule

// File: rtl/pll_cp_route.sv
module pll_cp_route
    import pll_lock_pkg::*;
(
    input  logic   lock_i,
    input  logic   ctl_en_i,
    input  logic   cur_hi_sw_i,
    input  logic   filt_sel_i,
    input  logic   pin_sel_i,
    input  logic   gpo_i,
    output drive_t drv_o
);
    always_comb begin
        drv_o.cp_high = ctl_en_i ? !lock_i : cur_hi_sw_i;
        drv_o.f_hc    = drv_o.cp_high;
        drv_o.f_fm    = !drv_o.cp_high && filt_sel_i;
        drv_o.f_am    = !drv_o.cp_high && !filt_sel_i;
        drv_o.pin     = pin_sel_i ? lock_i : gpo_i;
    end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import pll_lock_pkg::*;
#(
    parameter int UNIT_CYC = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       up_i,
    input  logic       dn_i,
    input  logic       ref_tick_i,
    input  logic       standby_i,
    input  logic [1:0] thr_code_i,
    input  logic [1:0] dly_code_i,
    input  logic       lock_ctl_en_i,
    input  logic       cur_hi_sw_i,
    input  logic       pin_sel_i,
    input  logic       gpo_i,
    input  logic       filt_sel_i,
    output logic       lock_o,
    output logic       cp_high_o,
    output logic       filt_hc_o,
    output logic       filt_fm_o,
    output logic       filt_am_o,
    output logic       shared_pin_o
);
    localparam int MAX_LIM = 40 * UNIT_CYC;
    localparam int WID_W   = $clog2(MAX_LIM + 2);

    logic [WID_W-1:0]  limit;
    logic [GOOD_W-1:0] target;
    logic              big, tick_good, lock;
    drive_t            drv;

    always_comb begin
        limit  = WID_W'((int'(thr_code_i) + 1) * 10 * UNIT_CYC);
        target = run_target(dly_code_i);
    end

    pll_err_width #(.W(WID_W), .SAT(MAX_LIM + 1)) u_width (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .standby_i   (standby_i),
        .up_i        (up_i),
        .dn_i        (dn_i),
        .tick_i      (ref_tick_i),
        .limit_i     (limit),
        .big_o       (big),
        .tick_good_o (tick_good)
    );

    pll_lock_seq u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .standby_i   (standby_i),
        .tick_i      (ref_tick_i),
        .tick_good_i (tick_good),
        .big_i       (big),
        .target_i    (target),
        .lock_o      (lock)
    );

    pll_cp_route u_route (
        .lock_i      (lock),
        .ctl_en_i    (lock_ctl_en_i),
        .cur_hi_sw_i (cur_hi_sw_i),
        .filt_sel_i  (filt_sel_i),
        .pin_sel_i   (pin_sel_i),
        .gpo_i       (gpo_i),
        .drv_o       (drv)
    );

    assign lock_o       = lock;
    assign cp_high_o    = drv.cp_high;
    assign filt_hc_o    = drv.f_hc;
    assign filt_fm_o    = drv.f_fm;
    assign filt_am_o    = drv.f_am;
    assign shared_pin_o = drv.pin;

    // R8
    one_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({filt_hc_o, filt_fm_o, filt_am_o}) == 1);

endmodule

// File: tb/pll_lock_monitor_bench.sv
`timescale 1ns/1ps
module pll_lock_monitor_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic up = 0, dn = 0, tick = 0, stby = 0;
    logic [1:0] thr = 0, dly = 2'b01;
    logic en = 1, cur_sw = 0, psel = 1, gpo = 0, fsel = 1;
    logic lock, cph, fhc, ffm, fam, pin;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    pll_lock_monitor u_pll_lock_monitor (
        .clk_i(clk), .rst_ni(rst_n), .up_i(up), .dn_i(dn), .ref_tick_i(tick),
        .standby_i(stby), .thr_code_i(thr), .dly_code_i(dly), .lock_ctl_en_i(en),
        .cur_hi_sw_i(cur_sw), .pin_sel_i(psel), .gpo_i(gpo), .filt_sel_i(fsel),
        .lock_o(lock), .cp_high_o(cph), .filt_hc_o(fhc), .filt_fm_o(ffm),
        .filt_am_o(fam), .shared_pin_o(pin)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clean();
        stby = 1; @(negedge clk); @(negedge clk); stby = 0;
    endtask

    // one 50-cycle interval: tick cycle, then w pulse samples, then idle
    task automatic run_interval(input int w, input bit use_dn);
        tick = 1; up = 0; dn = 0; @(negedge clk);
        tick = 0;
        for (int i = 0; i < w; i++) begin
            if (use_dn) dn = 1; else up = 1;
            @(negedge clk);
        end
        up = 0; dn = 0;
        repeat (49 - w) @(negedge clk);
    endtask

    task automatic get_lock();
        thr = 0; dly = 2'b01; clean();
        for (int k = 0; k < 4; k++) run_interval(0, 0);
    endtask

    task automatic t_reset();
        chk("R10 lock after reset", lock, 1'b0);
        chk("R10 high current after reset", cph, 1'b1);
        chk("R8 hc filter after reset", fhc, 1'b1);
        chk("R9 pin shows lock after reset", pin, 1'b0);
    endtask

    task automatic t_delay(input logic [1:0] code, input int n);
        thr = 0; dly = code; clean();
        for (int k = 1; k <= n; k++) begin
            run_interval(5, 0);
            if (k == n - 1) chk("R4 not yet locked", lock, 1'b0);
        end
        chk("R4 locked after N good", lock, 1'b1);
        chk("R7 low current when locked", cph, 1'b0);
    endtask

    task automatic t_overflow(input logic [1:0] code, input bit use_dn);
        int lim;
        get_lock();
        thr = code; lim = (int'(code) + 1) * 10;
        run_interval(lim, use_dn);
        chk("R2 width equal to limit keeps lock", lock, 1'b1);
        tick = 1; @(negedge clk); tick = 0;
        for (int i = 0; i < lim; i++) begin
            if (use_dn) dn = 1; else up = 1;
            @(negedge clk);
        end
        chk("R2 lock held at limit samples", lock, 1'b1);
        @(negedge clk);
        chk("R3 lock drops at limit+1 without tick", lock, 1'b0);
        chk("R7 high current after overflow", cph, 1'b1);
        up = 0; dn = 0;
        repeat (48 - lim) @(negedge clk);
    endtask

    task automatic t_restart();
        t_overflow(2'b00, 0);
        dly = 2'b10;
        for (int k = 1; k <= 7; k++) begin
            run_interval(0, 0);
            if (k == 6) chk("R5 bad interval not counted", lock, 1'b0);
        end
        chk("R5 relock after fresh run", lock, 1'b1);
    endtask

    task automatic t_straddle();
        get_lock();
        tick = 1; @(negedge clk); tick = 0;
        repeat (39) @(negedge clk);
        up = 1; repeat (10) @(negedge clk);
        tick = 1; @(negedge clk); tick = 0;
        chk("R1 old interval of limit closes good", lock, 1'b1);
        repeat (9) @(negedge clk);
        chk("R1 tick sample counted in new interval, at limit", lock, 1'b1);
        @(negedge clk);
        chk("R1 drop at 11th sample incl. tick cycle", lock, 1'b0);
        up = 0; repeat (30) @(negedge clk);
    endtask

    task automatic t_standby();
        get_lock();
        stby = 1; @(negedge clk);
        chk("R6 standby clears lock", lock, 1'b0);
        for (int k = 0; k < 3; k++) run_interval(0, 0);
        chk("R6 ticks ignored in standby", lock, 1'b0);
        stby = 0;
        for (int k = 1; k <= 4; k++) begin
            run_interval(0, 0);
            if (k == 3) chk("R6 count restarted from zero", lock, 1'b0);
        end
        chk("R6 relock after standby", lock, 1'b1);
    endtask

    task automatic t_sw_mode();
        get_lock();
        en = 0; cur_sw = 1; #1;
        chk("R7 sw high current while locked", cph, 1'b1);
        chk("R8 hc filter follows sw high", fhc, 1'b1);
        cur_sw = 0; #1;
        chk("R7 sw low current", cph, 1'b0);
        stby = 1; @(negedge clk);
        chk("R7 sw low despite unlock", cph, 1'b0);
        stby = 0; en = 1; #1;
        chk("R7 enabled and unlocked gives high", cph, 1'b1);
    endtask

    task automatic t_filter();
        get_lock();
        fsel = 1; #1;
        chk("R8 fm selected", ffm, 1'b1);
        chk("R8 am off", fam, 1'b0);
        fsel = 0; #1;
        chk("R8 am selected", fam, 1'b1);
        chk("R8 hc off when low current", fhc, 1'b0);
        fsel = 1;
    endtask

    task automatic t_pin();
        get_lock();
        psel = 0; gpo = 0; #1;
        chk("R9 pin shows gpo 0", pin, 1'b0);
        gpo = 1; #1;
        chk("R9 pin shows gpo 1", pin, 1'b1);
        psel = 1; gpo = 0; #1;
        chk("R9 pin shows lock", pin, 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        t_reset();
        t_delay(2'b01, 4);
        t_delay(2'b10, 6);
        t_delay(2'b11, 8);
        t_delay(2'b00, 8);
        t_overflow(2'b00, 0);
        t_overflow(2'b11, 1);
        t_overflow(2'b01, 0);
        t_restart();
        t_straddle();
        t_standby();
        t_sw_mode();
        t_filter();
        t_pin();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule